// File: doc/BRIEF.md
# Shift-and-add Q15 twiddle multiplier

This block multiplies a complex Q15 sample by one twiddle factor taken from the fixed coefficient set of a 16-point radix-4 first stage. It contains no multiplier and no coefficient table. A decoder turns a 4-bit coefficient index into a coefficient class and two weight selectors. The class is unit, minus-j or general. Each selector names one of three base constants (30273, 23170, 12539), an optional "+1" bump and an optional negation. Two shift-add units, one per real component of the sample, build the three base products. They use only two shared precomputed terms, 5x and 65x. Each unit then forms the products by the real weight and by the imaginary weight.

A negative weight is one's complement of a base constant. It equals minus (base + 1). It is therefore made by adding the operand to the base product and then negating. Unit samples bypass the arithmetic. Minus-j samples only swap their parts and negate one of them. General samples are combined, rounded and saturated.

Samples are accepted whenever `in_valid` is high, one per clock. Each result appears after exactly two register stages. Samples of different classes may follow each other back to back.

Top module: `twiddle_shiftadd_mul`

## Requirements
- R1: A sample accepted at a rising edge with `in_valid` high appears on `out_re`/`out_im` after the next rising edge. `out_valid` equals `in_valid` delayed by two edges. Consecutive samples flow without gaps.
- R2: Indices 0, 1, 2, 3, 4, 8 and 12 select the unit coefficient (real 0x7fff, imaginary 0x0000). For these the output equals the input bit for bit.
- R3: Index 10 selects minus-j (real 0x0000, imaginary 0x8000). The output real part is the input imaginary part. The output imaginary part is the negated input real part, and a negated -32768 gives 32767.
- R4: The remaining indices select W^k with these signed 16-bit weights (real, imaginary): index 5 is k=1 (30273, -12540); indices 6 and 9 are k=2 (23170, -23171); indices 7 and 13 are k=3 (12539, -30274); indices 11 and 14 are k=6 (-23171, -23171); index 15 is k=9 (-30274, 12539).
- R5: For a general coefficient the products are exact: real = Xr·Wr − Xi·Wi, imaginary = Xr·Wi + Xi·Wr. Each is rounded by adding 2^14 and shifting right arithmetically by 15.
- R6: A rounded general result above 32767 becomes 32767, and one below -32768 becomes -32768.
- R7: After reset the outputs are zero and `out_valid` is low.
- R8: While `in_valid` is low, changes on `in_re`, `in_im` and `in_idx` are ignored. The outputs keep the last result and `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_idx | input | 4 | Coefficient index 0..15 |
| in_re | input | 16 | Sample real part, signed Q15 |
| in_im | input | 16 | Sample imaginary part, signed Q15 |
| out_valid | output | 1 | Result qualifier, two edges after input |
| out_re | output | 16 | Product real part, signed Q15 |
| out_im | output | 16 | Product imaginary part, signed Q15 |

## Verification
The class decode and shift-add work for a new sample take place in the same cycle as the output selection for the previous sample. A bypass class can therefore leave the output stage while a general sample is being multiplied, and the reverse can happen too. The bench provokes this by driving a continuous valid stream whose index steps through all sixteen values. Each output is compared, two edges later, with an integer reference computed from R2 to R6. Saturation is tested on the same path with full-scale operands that overflow after rounding.

// File: rtl/twq_pkg.sv
package twq_pkg;

    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned FRAC_W   = 15;
    localparam int unsigned IDX_W    = 4;
    localparam int unsigned PROD_W   = 2 * SAMPLE_W + 2;

    typedef enum logic [1:0] {
        CK_UNIT,
        CK_NEGJ,
        CK_GENERAL
    } coef_kind_e;

    // base constants: HI = 30273, MID = 23170, LO = 12539
    typedef enum logic [1:0] {
        BASE_HI,
        BASE_MID,
        BASE_LO
    } base_e;

    typedef struct packed {
        base_e base;
        logic  bump;    // add the operand once more (base + 1)
        logic  negate;  // negate the bumped product
    } weight_sel_t;

endpackage

// File: rtl/twq_decode.sv
module twq_decode
    import twq_pkg::*;
#(
    parameter int unsigned IW = IDX_W
) (
    input  logic [IW-1:0] idx,
    output coef_kind_e    kind,
    output weight_sel_t   wr_sel,
    output weight_sel_t   wi_sel
);

    localparam weight_sel_t SEL_HI     = '{base: BASE_HI,  bump: 1'b0, negate: 1'b0};
    localparam weight_sel_t SEL_MID    = '{base: BASE_MID, bump: 1'b0, negate: 1'b0};
    localparam weight_sel_t SEL_LO     = '{base: BASE_LO,  bump: 1'b0, negate: 1'b0};
    localparam weight_sel_t SEL_HI_NC  = '{base: BASE_HI,  bump: 1'b1, negate: 1'b1};
    localparam weight_sel_t SEL_MID_NC = '{base: BASE_MID, bump: 1'b1, negate: 1'b1};
    localparam weight_sel_t SEL_LO_NC  = '{base: BASE_LO,  bump: 1'b1, negate: 1'b1};

    logic [3:0] expo;

    // index to twiddle exponent for the first radix-4 stage
    always_comb begin
        unique case (idx)
            4'd5:         expo = 4'd1;
            4'd6, 4'd9:   expo = 4'd2;
            4'd7, 4'd13:  expo = 4'd3;
            4'd10:        expo = 4'd4;
            4'd11, 4'd14: expo = 4'd6;
            4'd15:        expo = 4'd9;
            default:      expo = 4'd0;
        endcase
    end

    // exponent to class and channel selection; the swap between
    // (LO, HI') and (HI', LO) pairs is done purely by the selectors
    always_comb begin
        kind   = CK_GENERAL;
        wr_sel = SEL_HI;
        wi_sel = SEL_HI;
        unique case (expo)
            4'd1: begin wr_sel = SEL_HI;     wi_sel = SEL_LO_NC;  end
            4'd2: begin wr_sel = SEL_MID;    wi_sel = SEL_MID_NC; end
            4'd3: begin wr_sel = SEL_LO;     wi_sel = SEL_HI_NC;  end
            4'd6: begin wr_sel = SEL_MID_NC; wi_sel = SEL_MID_NC; end
            4'd9: begin wr_sel = SEL_HI_NC;  wi_sel = SEL_LO;     end
            4'd4: kind = CK_NEGJ;
            default: kind = CK_UNIT;
        endcase
    end

endmodule

// File: rtl/twq_const_unit.sv
module twq_const_unit
    import twq_pkg::*;
#(
    parameter int unsigned DW = SAMPLE_W,
    parameter int unsigned PW = PROD_W
) (
    input  logic signed [DW-1:0] v,
    input  weight_sel_t          sel_a,
    input  weight_sel_t          sel_b,
    output logic signed [PW-1:0] prod_a,
    output logic signed [PW-1:0] prod_b
);

    localparam int unsigned LANES = 2;

    logic signed [PW-1:0] x, x5, x65;
    logic signed [PW-1:0] p_hi, p_mid, p_lo;
    weight_sel_t          sel  [LANES];
    logic signed [PW-1:0] prod [LANES];

    assign x   = PW'(v);
    // shared subexpressions
    assign x5  = x + (x <<< 2);
    assign x65 = x + (x <<< 6);

    assign p_hi  = (x <<< 15) + x65 - (x5 <<< 9);
    assign p_mid = (x5 <<< 12) + (x5 <<< 9) + (x65 <<< 1);
    assign p_lo  = (x65 <<< 8) - (x <<< 12) - x5;

    assign sel[0] = sel_a;
    assign sel[1] = sel_b;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [PW-1:0] base_p;
        logic signed [PW-1:0] bumped;
        always_comb begin
            case (sel[g].base)
                BASE_HI:  base_p = p_hi;
                BASE_MID: base_p = p_mid;
                BASE_LO:  base_p = p_lo;
                default:  base_p = '0;
            endcase
        end
        assign bumped  = sel[g].bump ? base_p + x : base_p;
        assign prod[g] = sel[g].negate ? -bumped : bumped;
    end

    assign prod_a = prod[0];
    assign prod_b = prod[1];

endmodule

// File: rtl/twq_round_sat.sv
module twq_round_sat #(
    parameter int unsigned IN_W  = 34,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned SHIFT = 15
) (
    input  logic signed [IN_W-1:0]  a,
    output logic signed [OUT_W-1:0] y
);

    localparam logic signed [IN_W-1:0] HALF = IN_W'(1) <<< (SHIFT - 1);
    localparam logic signed [IN_W-1:0] HI   = (IN_W'(1) <<< (OUT_W - 1)) - IN_W'(1);
    localparam logic signed [IN_W-1:0] LO   = -HI - IN_W'(1);

    logic signed [IN_W-1:0] rnd;

    assign rnd = (a + HALF) >>> SHIFT;

    always_comb begin
        if (rnd > HI)      y = HI[OUT_W-1:0];
        else if (rnd < LO) y = LO[OUT_W-1:0];
        else               y = rnd[OUT_W-1:0];
    end

endmodule

// File: rtl/twiddle_shiftadd_mul.sv
module twiddle_shiftadd_mul
    import twq_pkg::*;
#(
    parameter int unsigned DATA_W = SAMPLE_W,
    parameter int unsigned IW     = IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [IW-1:0]            in_idx,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im
);

    localparam int unsigned PW = 2 * DATA_W + 2;
    localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] MAXV = ~MINV;

    coef_kind_e  kind;
    weight_sel_t wr_sel, wi_sel;
    logic signed [DATA_W-1:0] op_re, op_im;
    logic signed [PW-1:0] p_rr, p_ri, p_ir, p_ii;

    twq_decode #(.IW(IW)) dec_i (
        .idx    (in_idx),
        .kind   (kind),
        .wr_sel (wr_sel),
        .wi_sel (wi_sel)
    );

    // operand isolation: shift-add units see zero unless needed
    assign op_re = (kind == CK_GENERAL) ? in_re : '0;
    assign op_im = (kind == CK_GENERAL) ? in_im : '0;

    twq_const_unit #(.DW(DATA_W), .PW(PW)) re_unit_i (
        .v      (op_re),
        .sel_a  (wr_sel),
        .sel_b  (wi_sel),
        .prod_a (p_rr),
        .prod_b (p_ri)
    );

    twq_const_unit #(.DW(DATA_W), .PW(PW)) im_unit_i (
        .v      (op_im),
        .sel_a  (wr_sel),
        .sel_b  (wi_sel),
        .prod_a (p_ir),
        .prod_b (p_ii)
    );

    // stage 1 registers
    logic                     s1_valid;
    coef_kind_e               s1_kind;
    logic signed [DATA_W-1:0] s1_re, s1_im;
    logic signed [PW-1:0]     s1_rr, s1_ri, s1_ir, s1_ii;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_kind  <= CK_UNIT;
            s1_re    <= '0;
            s1_im    <= '0;
            s1_rr    <= '0;
            s1_ri    <= '0;
            s1_ir    <= '0;
            s1_ii    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_kind <= kind;
                s1_re   <= in_re;
                s1_im   <= in_im;
                s1_rr   <= p_rr;
                s1_ri   <= p_ri;
                s1_ir   <= p_ir;
                s1_ii   <= p_ii;
            end
        end
    end

    // stage 2 combine, round, saturate
    logic signed [PW-1:0]     acc_re, acc_im;
    logic signed [DATA_W-1:0] gen_re, gen_im, neg_re;
    logic signed [DATA_W-1:0] nxt_re, nxt_im;

    assign acc_re = s1_rr - s1_ii;
    assign acc_im = s1_ri + s1_ir;

    twq_round_sat #(.IN_W(PW), .OUT_W(DATA_W), .SHIFT(FRAC_W)) rs_re_i (
        .a (acc_re),
        .y (gen_re)
    );

    twq_round_sat #(.IN_W(PW), .OUT_W(DATA_W), .SHIFT(FRAC_W)) rs_im_i (
        .a (acc_im),
        .y (gen_im)
    );

    assign neg_re = (s1_re == MINV) ? MAXV : -s1_re;

    always_comb begin
        unique case (s1_kind)
            CK_NEGJ:    begin nxt_re = s1_im;  nxt_im = neg_re; end
            CK_GENERAL: begin nxt_re = gen_re; nxt_im = gen_im; end
            default:    begin nxt_re = s1_re;  nxt_im = s1_im;  end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_re <= nxt_re;
                out_im <= nxt_im;
            end
        end
    end

endmodule

// File: rtl/twq_checker.sv
module twq_checker (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_idx,
    input logic signed [15:0] in_re,
    input logic signed [15:0] in_im,
    input logic              out_valid,
    input logic signed [15:0] out_re,
    input logic signed [15:0] out_im
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_unit_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid &&
         ($past(in_idx, 2) <= 4'd4 || $past(in_idx, 2) == 4'd8 || $past(in_idx, 2) == 4'd12))
        |-> (out_re == $past(in_re, 2) && out_im == $past(in_im, 2)));

    assert_minus_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid && $past(in_idx, 2) == 4'd10)
        |-> (out_re == $past(in_im, 2) &&
             out_im == (($past(in_re, 2) == -16'sd32768) ? 16'sd32767 : -$past(in_re, 2))));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && !$past(in_valid))
        |=> ($stable(out_re) && $stable(out_im) && !out_valid));

endmodule

bind twiddle_shiftadd_mul twq_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_idx    (in_idx),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/twiddle_shiftadd_mul_tb_top.sv
`timescale 1ns/1ps
module twiddle_shiftadd_mul_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0]        in_idx = '0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic              out_valid;
    logic signed [15:0] out_re, out_im;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    twiddle_shiftadd_mul dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // reference from R2..R6
    task automatic ref_mul(input int idx, input int xr, input int xi,
                           output int yr, output int yi);
        int k, wr, wi;
        longint pr, pi;
        case (idx)
            5: k = 1;
            6, 9: k = 2;
            7, 13: k = 3;
            10: k = 4;
            11, 14: k = 6;
            15: k = 9;
            default: k = 0;
        endcase
        wr = 0; wi = 0;
        case (k)
            1: begin wr = 30273;  wi = -12540; end
            2: begin wr = 23170;  wi = -23171; end
            3: begin wr = 12539;  wi = -30274; end
            6: begin wr = -23171; wi = -23171; end
            9: begin wr = -30274; wi = 12539;  end
            default: ;
        endcase
        if (k == 0) begin
            yr = xr; yi = xi;
        end else if (k == 4) begin
            yr = xi; yi = sat16(-longint'(xr));
        end else begin
            pr = longint'(xr) * wr - longint'(xi) * wi;
            pi = longint'(xr) * wi + longint'(xi) * wr;
            yr = sat16((pr + 16384) >>> 15);
            yi = sat16((pi + 16384) >>> 15);
        end
    endtask

    task automatic one_sample(input string tag, input int idx, input int xr, input int xi);
        int er, ei;
        ref_mul(idx, xr, xi, er, ei);
        @(negedge clk);
        in_valid = 1'b1; in_idx = 4'(idx); in_re = 16'(xr); in_im = 16'(xi);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({tag, " valid"}, int'(out_valid), 1);
        check({tag, " re"}, int'(out_re), er);
        check({tag, " im"}, int'(out_im), ei);
    endtask

    task automatic t_reset;
        check("R7 valid", int'(out_valid), 0);
        check("R7 re", int'(out_re), 0);
        check("R7 im", int'(out_im), 0);
    endtask

    task automatic t_unit;
        int list [7] = '{0, 1, 2, 3, 4, 8, 12};
        foreach (list[i]) begin
            logic [15:0] a = 16'($urandom);
            logic [15:0] b = 16'($urandom);
            one_sample("R2 unit", list[i], int'($signed(a)), int'($signed(b)));
        end
        one_sample("R2 unit extreme", 0, -32768, 32767);
    endtask

    task automatic t_minus_j;
        one_sample("R3 minus-j", 10, 1234, -5678);
        one_sample("R3 minus-j min", 10, -32768, 77);
        check("R3 min negate", int'(out_im), 32767);
    endtask

    task automatic t_general;
        for (int idx = 0; idx < 16; idx++) begin
            for (int n = 0; n < 4; n++) begin
                logic [15:0] a = 16'($urandom);
                logic [15:0] b = 16'($urandom);
                one_sample("R4 R5 index sweep", idx, int'($signed(a)), int'($signed(b)));
            end
        end
        one_sample("R5 half-scale W1", 5, 16384, -16384);
    endtask

    task automatic t_saturate;
        one_sample("R6 positive", 15, -32768, -32768);
        check("R6 positive clamp", int'(out_re), 32767);
        one_sample("R6 negative", 11, 32767, -32768);
        check("R6 negative clamp", int'(out_re), -32768);
        check("R6 im small", int'(out_im), 1);
    endtask

    task automatic t_hold;
        int kr, ki;
        one_sample("R8 seed", 6, 20000, -3000);
        kr = int'(out_re); ki = int'(out_im);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            in_idx = 4'(n + 9); in_re = 16'($urandom); in_im = 16'($urandom);
        end
        @(negedge clk);
        check("R8 hold valid", int'(out_valid), 0);
        check("R8 hold re", int'(out_re), kr);
        check("R8 hold im", int'(out_im), ki);
    endtask

    task automatic t_stream;
        int er [40];
        int ei [40];
        for (int i = 0; i < 42; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R1 stream valid", int'(out_valid), 1);
                check("R1 stream re", int'(out_re), er[i-2]);
                check("R1 stream im", int'(out_im), ei[i-2]);
            end
            if (i < 40) begin
                logic [15:0] a = 16'($urandom);
                logic [15:0] b = 16'($urandom);
                int xr = int'($signed(a));
                int xi = int'($signed(b));
                ref_mul(i % 16, xr, xi, er[i], ei[i]);
                in_valid = 1'b1; in_idx = 4'(i % 16); in_re = a; in_im = b;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R1 stream end", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unit();
        t_minus_j();
        t_general();
        t_saturate();
        t_hold();
        t_stream();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule